// File: doc/BRIEF.md
# Colour Expansion Writer

This unit turns one byte written by the host into a run of eight pixel writes to video memory. Each bit of the byte, from the top bit down, picks either the foreground or the background colour. The pixels go to consecutive addresses above a base byte address. At 8 bits per pixel each pixel is a single byte. At 16 bits per pixel each pixel is two bytes, and the low and high colour bytes come from separate colour registers.

Two write modes use the expansion. The transparent mode writes only the pixels whose bit is set and skips the rest, although the address still moves past them. The opaque mode writes all eight pixels. Any other mode, or the expansion enable held low, turns the host byte into one plain byte write. The unit drives one pixel per clock through a write port with two byte-lane enables. It raises `busy` while a run is in flight and accepts no new byte until the run is over.

The unit holds four colour registers: the low and high bytes of the background and of the foreground. The two low-byte registers keep all eight bits for the expansion, but only their low nibble is visible on the readback port.

Top module: `cexp_writer`

## Requirements
- R1: Expansion runs only when `expandEn` is 1 and `writeMode` is 4 (transparent) or 5 (opaque). Otherwise an accepted byte makes exactly one write in the cycle after acceptance: address `baseAddr`, `memData` = {8'h00, byte}, `memBe` = 2'b01.
- R2: An accepted byte in an expansion mode takes exactly 8 cycles, one pixel per cycle, starting the cycle after acceptance. Pixel i (i = 0..7) belongs to byte bit 7-i and sits at `baseAddr` + i × pixel size.
- R3: A pixel whose bit is set is written with the foreground colour.
- R4: In mode 5 a pixel whose bit is clear is written with the background colour. In mode 4 that pixel is not written (`memWe` = 0), but its address slot is still used.
- R5: With `pixWide` = 0 the pixel size is 1 byte. `memBe` is 2'b01, `memData[7:0]` holds the colour low byte, and one run spans 8 bytes.
- R6: With `pixWide` = 1 the pixel size is 2 bytes and `memBe` is 2'b11. `memData[7:0]` comes from the low-byte register (select 1 foreground, select 0 background) and `memData[15:8]` from the high-byte register (select 3 foreground, select 2 background). One run spans 16 bytes.
- R7: Colour register selects are 0 = background low, 1 = foreground low, 2 = background high, 3 = foreground high. Reading back select 0 or 1 returns the stored value with bits 7:4 forced to 0, while the expansion uses all 8 stored bits. Selects 2 and 3 read back in full.
- R8: `busy` is 1 from the cycle after acceptance through the last write of the run. A byte offered while `busy` is 1 is dropped and makes no write.
- R9: Colours, mode, pixel width and base address are captured when the byte is accepted. A register write during a run changes the register but affects only later bytes.
- R10: Pixel addresses wrap modulo 2^`ADDR_W`.
- R11: After reset `busy` and `memWe` are 0 and all colour registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWr | input | 1 | Host byte write strobe |
| cpuData | input | 8 | Host data byte |
| writeMode | input | 3 | Write mode; 4 transparent, 5 opaque |
| expandEn | input | 1 | Extended expansion enable |
| pixWide | input | 1 | 0 = 8 bpp, 1 = 16 bpp |
| baseAddr | input | ADDR_W | Byte address of the first pixel |
| regWr | input | 1 | Colour register write strobe |
| regSel | input | 2 | Colour register written |
| regWrData | input | 8 | Colour register write data |
| regRdSel | input | 2 | Colour register read back |
| regRdData | output | 8 | Readback value |
| busy | output | 1 | Run in flight |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory byte address |
| memData | output | 16 | Write data, low lane at memAddr |
| memBe | output | 2 | Byte-lane enables |

## Verification
The hardest case to reach from the ports is a colour register write and a second host byte that both arrive in the middle of a run. The bench starts an opaque run and, on the third pixel, drives a new foreground value and a new byte in the same cycle. It then checks that the remaining pixels keep the captured colour and that the run keeps its length. It also checks that the register reads back the new value and that the next byte is the first one to use it. A second case that is hard to reach is a 16 bpp run whose base sits three bytes below the top of the address space, so the pixel addresses wrap in the middle of the run.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
  localparam int PIX_PER_BYTE = 8;
  localparam int IDX_W = $clog2(PIX_PER_BYTE);
  localparam int COLOUR_REGS = 4;

  localparam logic [2:0] WMODE_TRANSP = 3'd4;
  localparam logic [2:0] WMODE_OPAQUE = 3'd5;

  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_EXPAND = 2'd1,
    CS_PLAIN  = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic             load;      // capture byte and context
    logic             emitPix;   // expansion pixel this cycle
    logic             emitPlain; // single plain byte this cycle
    logic [IDX_W-1:0] pixIdx;    // pixel position within the run
  } ctlStrobe_t;
endpackage

// File: rtl/cexp_ctl.sv
module cexp_ctl
  import cexp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWr,
  input  logic [2:0] writeMode,
  input  logic       expandEn,
  output ctlStrobe_t strobe,
  output logic       busy
);
  ctlState_t        state, stateNxt;
  logic [IDX_W-1:0] cnt;
  logic             accept, expandHit, lastPix;

  always_comb begin
    accept    = cpuWr && (state == CS_IDLE);
    expandHit = expandEn && ((writeMode == WMODE_TRANSP) || (writeMode == WMODE_OPAQUE));
    lastPix   = (cnt == IDX_W'(PIX_PER_BYTE - 1));
    stateNxt  = state;
    case (state)
      CS_IDLE:   if (accept) stateNxt = expandHit ? CS_EXPAND : CS_PLAIN;
      CS_EXPAND: if (lastPix) stateNxt = CS_IDLE;
      CS_PLAIN:  stateNxt = CS_IDLE;
      default:   stateNxt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CS_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      if (state == CS_EXPAND && !lastPix) cnt <= cnt + 1'b1;
      else                                cnt <= '0;
    end
  end

  always_comb begin
    strobe.load      = accept;
    strobe.emitPix   = (state == CS_EXPAND);
    strobe.emitPlain = (state == CS_PLAIN);
    strobe.pixIdx    = cnt;
    busy             = (state != CS_IDLE);
  end
endmodule

// File: rtl/cexp_dp.sv
module cexp_dp
  import cexp_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        cpuData,
  input  logic [2:0]        writeMode,
  input  logic              pixWide,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWrData,
  input  logic [1:0]        regRdSel,
  output logic [7:0]        regRdData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic [1:0]        memBe
);
  localparam int OFF_W = IDX_W + 1;

  logic [7:0]        colourReg [COLOUR_REGS];
  logic [15:0]       fgQ, bgQ;
  logic              opaqueQ, wideQ;
  logic [ADDR_W-1:0] baseQ;
  logic [7:0]        shiftQ;
  logic              curBit;
  logic [OFF_W-1:0]  pixOff;

  for (genvar g = 0; g < COLOUR_REGS; g++) begin : g_creg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               colourReg[g] <= '0;
      else if (regWr && (regSel == 2'(g)))     colourReg[g] <= regWrData;
    end
  end

  // Low-byte registers show only their low nibble on readback
  always_comb begin
    if (regRdSel[1]) regRdData = colourReg[regRdSel];
    else             regRdData = {4'h0, colourReg[regRdSel][3:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fgQ     <= '0;
      bgQ     <= '0;
      opaqueQ <= 1'b0;
      wideQ   <= 1'b0;
      baseQ   <= '0;
      shiftQ  <= '0;
    end else if (strobe.load) begin
      fgQ     <= {colourReg[3], colourReg[1]};
      bgQ     <= {colourReg[2], colourReg[0]};
      opaqueQ <= (writeMode == WMODE_OPAQUE);
      wideQ   <= pixWide;
      baseQ   <= baseAddr;
      shiftQ  <= cpuData;
    end else if (strobe.emitPix) begin
      shiftQ  <= {shiftQ[6:0], 1'b0};
    end
  end

  always_comb begin
    curBit  = shiftQ[7];
    pixOff  = wideQ ? {strobe.pixIdx, 1'b0} : {1'b0, strobe.pixIdx};
    memAddr = baseQ + ADDR_W'(pixOff);
    memWe   = strobe.emitPlain | (strobe.emitPix & (curBit | opaqueQ));
    if (strobe.emitPix) memData = curBit ? fgQ : bgQ;
    else                memData = {8'h00, shiftQ};
    memBe   = (strobe.emitPix && wideQ) ? 2'b11 : 2'b01;
  end
endmodule

// File: rtl/cexp_writer.sv
module cexp_writer
  import cexp_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [7:0]        cpuData,
  input  logic [2:0]        writeMode,
  input  logic              expandEn,
  input  logic              pixWide,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [7:0]        regWrData,
  input  logic [1:0]        regRdSel,
  output logic [7:0]        regRdData,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memData,
  output logic [1:0]        memBe
);
  ctlStrobe_t strobe;

  cexp_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .writeMode(writeMode),
    .expandEn(expandEn), .strobe(strobe), .busy(busy)
  );

  cexp_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuData(cpuData),
    .writeMode(writeMode), .pixWide(pixWide), .baseAddr(baseAddr),
    .regWr(regWr), .regSel(regSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .memBe(memBe)
  );
endmodule

// File: rtl/cexp_writer_chk.sv
module cexp_writer_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuWr,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memBe,
  input logic [1:0]        regRdSel,
  input logic [7:0]        regRdData
);
  logic [3:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
    else           runLen <= '0;
  end

  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !busy) |=> busy);

  a_r8_write_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  a_r2_run_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == 4'd8 || runLen == 4'd1));

  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |->
      (memAddr == $past(memAddr) + ADDR_W'((memBe == 2'b11) ? 2 : 1)));

  a_r5_lane_shape: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memBe == 2'b01 || memBe == 2'b11));

  a_r7_low_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (regRdSel[1] == 1'b0) |-> (regRdData[7:4] == 4'h0));
endmodule

bind cexp_writer cexp_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .busy(busy), .memWe(memWe),
  .memAddr(memAddr), .memBe(memBe), .regRdSel(regRdSel), .regRdData(regRdData)
);

// File: tb/cexp_writer_tb.sv
module cexp_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 22;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuWr = 1'b0;
  logic [7:0]    cpuData = '0;
  logic [2:0]    writeMode = '0;
  logic          expandEn = 1'b0;
  logic          pixWide = 1'b0;
  logic [AW-1:0] baseAddr = '0;
  logic          regWr = 1'b0;
  logic [1:0]    regSel = '0;
  logic [7:0]    regWrData = '0;
  logic [1:0]    regRdSel = '0;
  logic [7:0]    regRdData;
  logic          busy, memWe;
  logic [AW-1:0] memAddr;
  logic [15:0]   memData;
  logic [1:0]    memBe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cexp_writer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuData(cpuData),
    .writeMode(writeMode), .expandEn(expandEn), .pixWide(pixWide),
    .baseAddr(baseAddr), .regWr(regWr), .regSel(regSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .memBe(memBe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWr = 1'b0;
    model[sel] = val;
  endtask

  task automatic readCheck(input logic [1:0] sel, input string req);
    logic [7:0] exp;
    exp = sel[1] ? model[sel] : {4'h0, model[sel][3:0]};
    regRdSel = sel;
    #1;
    chk(req, "readback", 32'(regRdData), 32'(exp));
  endtask

  // R11: reset state
  task automatic testReset();
    chk("R11", "busy", 32'(busy), 0);
    chk("R11", "memWe", 32'(memWe), 0);
    for (int s = 0; s < 4; s++) begin
      regRdSel = 2'(s);
      #1;
      chk("R11", "reg reads 0", 32'(regRdData), 0);
    end
  endtask

  // R1: plain single write path
  task automatic plainRun(input logic [7:0] d, input logic [2:0] m,
                          input logic en, input logic [AW-1:0] base);
    @(negedge clk);
    cpuWr = 1'b1; cpuData = d; writeMode = m; expandEn = en; baseAddr = base;
    @(negedge clk);
    cpuWr = 1'b0;
    chk("R1", "plain we", 32'(memWe), 1);
    chk("R1", "plain addr", 32'(memAddr), 32'(base));
    chk("R1", "plain data", 32'(memData), 32'({8'h00, d}));
    chk("R1", "plain be", 32'(memBe), 32'(2'b01));
    @(negedge clk);
    chk("R1", "plain one cycle busy", 32'(busy), 0);
    chk("R1", "plain one cycle we", 32'(memWe), 0);
  endtask

  // R2..R6, R8..R10: expansion run; inject tests mid-run traffic
  task automatic expandRun(input logic [7:0] d, input logic [2:0] m,
                           input logic wide, input logic [AW-1:0] base,
                           input string req, input logic inject,
                           input logic [7:0] newFg);
    logic [15:0] fg, bg, expData;
    logic [AW-1:0] expAddr;
    logic bitv, expWe;
    fg = {model[3], model[1]};
    bg = {model[2], model[0]};
    @(negedge clk);
    cpuWr = 1'b1; cpuData = d; writeMode = m; expandEn = 1'b1;
    pixWide = wide; baseAddr = base;
    @(negedge clk);
    cpuWr = 1'b0;
    for (int i = 0; i < 8; i++) begin
      bitv    = d[7-i];
      expWe   = bitv || (m == 3'd5);
      expAddr = base + AW'(wide ? 2*i : i);
      expData = bitv ? fg : bg;
      chk(req, "busy in run", 32'(busy), 1);
      chk(req, "pixel we", 32'(memWe), 32'(expWe));
      chk(req, "pixel addr", 32'(memAddr), 32'(expAddr));
      chk(req, "pixel be", 32'(memBe), wide ? 32'(2'b11) : 32'(2'b01));
      if (expWe) begin
        if (wide) chk(req, "pixel data16", 32'(memData), 32'(expData));
        else      chk(req, "pixel data8", 32'(memData[7:0]), 32'(expData[7:0]));
      end
      if (inject && i == 2) begin
        cpuWr = 1'b1; cpuData = 8'hFF;
        regWr = 1'b1; regSel = 2'd1; regWrData = newFg;
      end else if (inject && i == 3) begin
        cpuWr = 1'b0; regWr = 1'b0;
        model[1] = newFg;
      end
      if (i < 7) @(negedge clk);
    end
    @(negedge clk);
    chk("R8", "busy clears after 8", 32'(busy), 0);
    chk("R8", "no write after run", 32'(memWe), 0);
    if (inject) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R8", "dropped byte makes no write", 32'(memWe), 0);
        chk("R8", "dropped byte not busy", 32'(busy), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);

    // R7: registers, readback mask
    writeReg(2'd0, 8'hA7);
    writeReg(2'd1, 8'h5C);
    writeReg(2'd2, 8'h3E);
    writeReg(2'd3, 8'hD1);
    for (int s = 0; s < 4; s++) readCheck(2'(s), "R7");

    // R3 R4 R5: opaque 8 bpp (full 8-bit low colours used, R7)
    expandRun(8'hB4, 3'd5, 1'b0, 22'h000100, "R4_R5", 1'b0, 8'h00);
    // R4: transparent 8 bpp
    expandRun(8'h96, 3'd4, 1'b0, 22'h000200, "R4", 1'b0, 8'h00);
    // R6: opaque and transparent 16 bpp
    expandRun(8'h5A, 3'd5, 1'b1, 22'h001000, "R6", 1'b0, 8'h00);
    expandRun(8'hC3, 3'd4, 1'b1, 22'h002000, "R6", 1'b0, 8'h00);
    // R3: all set
    expandRun(8'hFF, 3'd4, 1'b0, 22'h000300, "R3", 1'b0, 8'h00);
    // R10: wrap at the top of the address space
    expandRun(8'hA5, 3'd5, 1'b1, 22'h3FFFFD, "R10", 1'b0, 8'h00);
    // R1: disabled expansion and a non-expansion mode
    plainRun(8'h6B, 3'd4, 1'b0, 22'h000400);
    plainRun(8'h2C, 3'd6, 1'b1, 22'h000500);
    // R9 R8: register write and new byte mid-run
    expandRun(8'hE1, 3'd5, 1'b0, 22'h000600, "R9", 1'b1, 8'h9F);
    readCheck(2'd1, "R9");
    expandRun(8'h81, 3'd5, 1'b0, 22'h000700, "R9", 1'b0, 8'h00);
    // R2: MSB-first ordering check on a single set bit
    expandRun(8'h01, 3'd4, 1'b0, 22'h000800, "R2", 1'b0, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog run hung actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule